// File: doc/BRIEF.md
# Tributary Transmit Elastic Store

This block buffers one low-rate tributary (a DS1/E1 stream, or a VT1.5/VT2 stream taken back through the loopback path) on its way into a SONET/SDH mapper. Tributary bits arrive with a write strobe. The mapper pulls them out one at a time with a read strobe at the local frame rate. The store is a 128-entry bit FIFO. It sits on the system clock, and the tributary write strobe is retimed into that domain before it reaches the block. The fill level is the write pointer minus the read pointer, modulo 128.

At every justification opportunity that the mapper signals, the block compares the fill level with a high and a low threshold and registers a two-bit decision. A full store asks for negative justification (data carried in the stuff bit). A draining store asks for positive justification (stuff bit left empty). The thresholds are either a built-in pair or two programmed 7-bit values. The built-in pair depends on whether the loopback path feeds the store. In byte-synchronous mapping no bit stuffing takes place.

A write that finds the store full is dropped and sets a sticky overflow event. The event drives an interrupt unless it is masked, and it is cleared by a one-cycle clear pulse. A recentre input puts the read pointer half the depth behind the write pointer.

Top module: `tes_elastic_store`

## Requirements
- R1: After asynchronous reset, `just_code` is 00, `ovf_event` is 0, `irq` is 0 and `rd_bit` is 0. The fill level is 64.
- R2: Bits leave in the order they were written. A read strobe (`rd_en`) in one cycle presents the oldest stored bit on `rd_bit` after that clock edge, and `rd_bit` holds until the next read.
- R3: A write while the fill level is 127 is dropped, so the fill stays at 127, and the write sets `ovf_event` at that clock edge.
- R4: `ovf_event` stays set until a cycle in which `ovf_clr` is 1 and no new overflow occurs. If an overflow and a clear occur in the same cycle, the event stays set.
- R5: `irq` is 1 exactly when `ovf_event` is 1 and `ovf_mask` is 0.
- R6: With `thr_prog` = 0, the thresholds are high 0x28 and low 0x27 when `loopback` = 0, and high 0x05 and low 0x04 when `loopback` = 1.
- R7: With `thr_prog` = 1, the thresholds are `hi_thr` and `lo_thr`.
- R8: On a cycle with `just_opp` = 1, the decision is 10 (negative) if fill ≥ high, otherwise 01 (positive) if fill ≤ low, otherwise 00 (none). The decision appears on `just_code` after that clock edge.
- R9: `just_code` changes only at the clock edge that follows a `just_opp` cycle, whatever the fill does in between.
- R10: `map_mode` encodes 00 asynchronous, 01 bit synchronous, 10 byte synchronous, and 11, which behaves as asynchronous. In byte-synchronous mode every decision is 00.
- R11: A cycle with `recentre` = 1 sets the fill level to 64 and drops any write or read in that cycle.
- R12: A read while the fill is 0 gives `rd_bit` = 0 and does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (STS-1/STS-3) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recentre | input | 1 | Synchronous recentre of the read pointer |
| wr_en | input | 1 | Tributary bit write strobe |
| wr_bit | input | 1 | Tributary data bit |
| rd_en | input | 1 | Read strobe from the mapper |
| rd_bit | output | 1 | Registered read data |
| just_opp | input | 1 | Justification opportunity strobe |
| map_mode | input | 2 | Mapping mode |
| loopback | input | 1 | 1 when the loopback VT path feeds the store |
| thr_prog | input | 1 | 1 selects the programmed thresholds |
| hi_thr | input | 7 | Programmed high (negative justification) threshold |
| lo_thr | input | 7 | Programmed low (positive justification) threshold |
| just_code | output | 2 | Registered justification decision |
| ovf_clr | input | 1 | Clear pulse for the overflow event |
| ovf_mask | input | 1 | Interrupt mask for the overflow event |
| ovf_event | output | 1 | Sticky overflow event |
| irq | output | 1 | Overflow interrupt |

## Verification
The fill level is not a port, so a pointer that slips shows up in two ways. It shows in the next justification decision, one edge after the strobe. It also shows as reordered or missing bits on `rd_bit`, one edge after each read. The bench therefore brings the fill out through decisions taken at known fill values on both sides of each threshold. A full store that wrongly accepts a write moves the fill to 0, so the following decision flips from negative to positive. A wrong event register shows on `irq` one edge after the overflow or the clear.

// File: rtl/tes_pkg.sv
package tes_pkg;

  localparam int unsigned TES_AW = 7;

  typedef enum logic [1:0] {
    JUST_NONE = 2'b00,
    JUST_POS  = 2'b01,
    JUST_NEG  = 2'b10
  } just_e;

  typedef enum logic [1:0] {
    MAP_ASYNC    = 2'b00,
    MAP_BITSYNC  = 2'b01,
    MAP_BYTESYNC = 2'b10,
    MAP_SPARE    = 2'b11
  } map_mode_e;

  // built-in threshold pairs for the direct and the looped-back source
  localparam logic [TES_AW-1:0] THR_HI_DIRECT = 7'h28;
  localparam logic [TES_AW-1:0] THR_LO_DIRECT = 7'h27;
  localparam logic [TES_AW-1:0] THR_HI_LOOP   = 7'h05;
  localparam logic [TES_AW-1:0] THR_LO_LOOP   = 7'h04;

endpackage

// File: rtl/tes_store.sv
module tes_store #(
  parameter int unsigned AW = tes_pkg::TES_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recentre,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic [AW-1:0] fill,
  output logic          ovf_pulse
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW-1:0] HALF_L = AW'(DEPTH / 2);
  localparam logic [AW-1:0] FULL_L = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE_L  = AW'(1);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic             rd_q, rd_d;
  logic             wr_ok, rd_ok, rd_take;

  assign fill = wptr_q - rptr_q;

  // next-state logic
  always_comb begin
    wr_ok     = wr_en && !recentre && (fill != FULL_L);
    rd_take   = rd_en && !recentre;
    rd_ok     = rd_take && (fill != '0);
    ovf_pulse = wr_en && !recentre && (fill == FULL_L);
    wptr_d    = wr_ok ? (wptr_q + ONE_L) : wptr_q;
    if (recentre)   rptr_d = wptr_q - HALF_L;
    else if (rd_ok) rptr_d = rptr_q + ONE_L;
    else            rptr_d = rptr_q;
    if (rd_ok)        rd_d = mem_q[rptr_q];
    else if (rd_take) rd_d = 1'b0;
    else              rd_d = rd_q;
  end

  // pointer and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= HALF_L;
      rd_q   <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      rd_q   <= rd_d;
    end
  end

  // data array: one enabled flop per entry, no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_ok && (wptr_q == AW'(g))) mem_q[g] <= wr_bit;
    end
  end

  assign rd_bit = rd_q;

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !recentre && fill == FULL_L) |=> (wptr_q == $past(wptr_q)));

  p_recentre_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recentre |=> (fill == HALF_L));

  p_empty_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !recentre && fill == '0) |=> (!rd_bit && rptr_q == $past(rptr_q)));

endmodule

// File: rtl/tes_just.sv
module tes_just
  import tes_pkg::*;
#(
  parameter int unsigned AW = tes_pkg::TES_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          just_opp,
  input  logic [1:0]    map_mode,
  input  logic          loopback,
  input  logic          thr_prog,
  input  logic [AW-1:0] hi_thr,
  input  logic [AW-1:0] lo_thr,
  input  logic [AW-1:0] fill,
  output just_e         code
);

  logic [AW-1:0] hi_sel, lo_sel;
  just_e         code_q, code_d;
  logic          stuff_on;

  always_comb begin
    if (thr_prog) begin
      hi_sel = hi_thr;
      lo_sel = lo_thr;
    end else if (loopback) begin
      hi_sel = AW'(THR_HI_LOOP);
      lo_sel = AW'(THR_LO_LOOP);
    end else begin
      hi_sel = AW'(THR_HI_DIRECT);
      lo_sel = AW'(THR_LO_DIRECT);
    end
    stuff_on = (map_mode != MAP_BYTESYNC);
    if (!stuff_on)            code_d = JUST_NONE;
    else if (fill >= hi_sel)  code_d = JUST_NEG;
    else if (fill <= lo_sel)  code_d = JUST_POS;
    else                      code_d = JUST_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= JUST_NONE;
    else if (just_opp) code_q <= code_d;
  end

  assign code = code_q;

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !just_opp |=> $stable(code_q));

  p_bytesync_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (just_opp && map_mode == MAP_BYTESYNC) |=> (code_q == JUST_NONE));

endmodule

// File: rtl/tes_irq.sv
module tes_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_pulse,
  input  logic clr,
  input  logic mask,
  output logic event_o,
  output logic irq
);

  logic event_q, event_d;

  always_comb begin
    if (ovf_pulse) event_d = 1'b1;
    else if (clr)  event_d = 1'b0;
    else           event_d = event_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= 1'b0;
    else        event_q <= event_d;
  end

  assign event_o = event_q;
  assign irq     = event_q & ~mask;

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q && !clr) |=> event_q);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> event_q);

endmodule

// File: rtl/tes_elastic_store.sv
module tes_elastic_store
  import tes_pkg::*;
#(
  parameter int unsigned AW = tes_pkg::TES_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recentre,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  input  logic          just_opp,
  input  logic [1:0]    map_mode,
  input  logic          loopback,
  input  logic          thr_prog,
  input  logic [AW-1:0] hi_thr,
  input  logic [AW-1:0] lo_thr,
  output logic [1:0]    just_code,
  input  logic          ovf_clr,
  input  logic          ovf_mask,
  output logic          ovf_event,
  output logic          irq
);

  logic [AW-1:0] fill;
  logic          ovf_pulse;
  just_e         code;

  tes_store #(.AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .recentre  (recentre),
    .wr_en     (wr_en),
    .wr_bit    (wr_bit),
    .rd_en     (rd_en),
    .rd_bit    (rd_bit),
    .fill      (fill),
    .ovf_pulse (ovf_pulse)
  );

  tes_just #(.AW(AW)) u_just (
    .clk      (clk),
    .rst_n    (rst_n),
    .just_opp (just_opp),
    .map_mode (map_mode),
    .loopback (loopback),
    .thr_prog (thr_prog),
    .hi_thr   (hi_thr),
    .lo_thr   (lo_thr),
    .fill     (fill),
    .code     (code)
  );

  tes_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_pulse (ovf_pulse),
    .clr       (ovf_clr),
    .mask      (ovf_mask),
    .event_o   (ovf_event),
    .irq       (irq)
  );

  assign just_code = code;

  p_irq_follows_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !ovf_mask) |=> (irq || ovf_mask));

endmodule

// File: tb/tes_elastic_store_test.sv
module tes_elastic_store_test;

  logic clk = 1'b0;
  logic rst_n, recentre, wr_en, wr_bit, rd_en, just_opp;
  logic [1:0] map_mode;
  logic loopback, thr_prog, ovf_clr, ovf_mask;
  logic [6:0] hi_thr, lo_thr;
  logic rd_bit, ovf_event, irq;
  logic [1:0] just_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tes_elastic_store uut (
    .clk(clk), .rst_n(rst_n), .recentre(recentre), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en(rd_en), .rd_bit(rd_bit), .just_opp(just_opp), .map_mode(map_mode),
    .loopback(loopback), .thr_prog(thr_prog), .hi_thr(hi_thr), .lo_thr(lo_thr),
    .just_code(just_code), .ovf_clr(ovf_clr), .ovf_mask(ovf_mask),
    .ovf_event(ovf_event), .irq(irq)
  );

  // {mode, loopback, prog, hi, lo, writes, reads, expected code}; fill = 64 + writes - reads
  localparam logic [35:0] VEC [0:11] = '{
    {2'd0, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd0,  2'd2},  // R6 fill 64 direct
    {2'd0, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd24, 2'd2},  // R8 fill 40 = high
    {2'd0, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd25, 2'd1},  // R8 fill 39 = low
    {2'd0, 1'b1, 1'b0, 7'd0,   7'd0,  8'd0,  8'd59, 2'd2},  // R6 loop fill 5
    {2'd0, 1'b1, 1'b0, 7'd0,   7'd0,  8'd0,  8'd60, 2'd1},  // R6 loop fill 4
    {2'd0, 1'b1, 1'b0, 7'd0,   7'd0,  8'd0,  8'd64, 2'd1},  // R8 fill 0
    {2'd0, 1'b0, 1'b1, 7'd100, 7'd20, 8'd0,  8'd0,  2'd0},  // R7 between
    {2'd0, 1'b0, 1'b1, 7'd100, 7'd20, 8'd36, 8'd0,  2'd2},  // R7 fill 100
    {2'd0, 1'b0, 1'b1, 7'd100, 7'd20, 8'd0,  8'd44, 2'd1},  // R7 fill 20
    {2'd2, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd25, 2'd0},  // R10 byte sync
    {2'd1, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd25, 2'd1},  // R10 bit sync
    {2'd3, 1'b0, 1'b0, 7'd0,   7'd0,  8'd0,  8'd0,  2'd2}   // R10 spare = async
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_recentre(); recentre = 1'b1; cyc(); recentre = 1'b0; endtask

  task automatic do_writes(input int n, input logic b);
    for (int i = 0; i < n; i++) begin wr_en = 1'b1; wr_bit = b; cyc(); end
    wr_en = 1'b0;
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1'b1; cyc(); end
    rd_en = 1'b0;
  endtask

  task automatic strobe(); just_opp = 1'b1; cyc(); just_opp = 1'b0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; recentre = 0; wr_en = 0; wr_bit = 0; rd_en = 0; just_opp = 0;
    map_mode = 2'd0; loopback = 0; thr_prog = 0; hi_thr = 0; lo_thr = 0;
    ovf_clr = 0; ovf_mask = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 code", 32'(just_code), 32'd0);
    check("R1 event", 32'(ovf_event), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rd_bit", 32'(rd_bit), 32'd0);
    thr_prog = 1; hi_thr = 7'd64; lo_thr = 7'd63; strobe();
    check("R1 fill 64 at reset", 32'(just_code), 32'd2);
    hi_thr = 7'd65; lo_thr = 7'd64; strobe();
    check("R1 fill 64 at reset low side", 32'(just_code), 32'd1);

    // vector table
    foreach (VEC[k]) begin
      map_mode = VEC[k][35:34]; loopback = VEC[k][33]; thr_prog = VEC[k][32];
      hi_thr = VEC[k][31:25]; lo_thr = VEC[k][24:18];
      do_recentre();
      do_writes(int'(VEC[k][17:10]), 1'b1);
      do_reads(int'(VEC[k][9:2]));
      strobe();
      check($sformatf("R8 vector %0d", k), 32'(just_code), 32'(VEC[k][1:0]));
    end

    // R11: recentre drops same-cycle write and sets fill 64
    map_mode = 0; thr_prog = 1; hi_thr = 7'd65; lo_thr = 7'd64;
    do_writes(10, 1'b1);
    recentre = 1; wr_en = 1; cyc(); recentre = 0; wr_en = 0;
    strobe();
    check("R11 fill 64 after recentre", 32'(just_code), 32'd1);

    // R2 order, R12 empty read
    do_recentre(); do_reads(64);
    begin
      logic [19:0] pat = 20'b1011_0011_1000_1101_0110;
      for (int i = 0; i < 20; i++) begin wr_en = 1; wr_bit = pat[i]; cyc(); end
      wr_en = 0;
      for (int i = 0; i < 20; i++) begin
        rd_en = 1; cyc();
        check($sformatf("R2 bit %0d", i), 32'(rd_bit), 32'(pat[i]));
      end
      rd_en = 0; cyc();
      check("R2 rd_bit held", 32'(rd_bit), 32'(pat[19]));
    end
    do_reads(1);
    check("R12 empty read gives 0", 32'(rd_bit), 32'd0);
    do_writes(1, 1'b1); do_reads(1);
    check("R12 pointer held", 32'(rd_bit), 32'd1);

    // R3/R4/R5 overflow
    do_recentre(); do_writes(63, 1'b1);
    check("R3 no event at 127", 32'(ovf_event), 32'd0);
    do_writes(1, 1'b0);
    check("R3 event on full write", 32'(ovf_event), 32'd1);
    check("R5 irq unmasked", 32'(irq), 32'd1);
    hi_thr = 7'd127; lo_thr = 7'd0; strobe();
    check("R3 fill stays 127", 32'(just_code), 32'd2);
    ovf_mask = 1; #1;
    check("R5 irq masked", 32'(irq), 32'd0);
    check("R4 event kept under mask", 32'(ovf_event), 32'd1);
    ovf_mask = 0; cyc();
    check("R4 event sticky", 32'(ovf_event), 32'd1);
    ovf_clr = 1; cyc(); ovf_clr = 0;
    check("R4 cleared", 32'(ovf_event), 32'd0);
    check("R5 irq cleared", 32'(irq), 32'd0);
    wr_en = 1; ovf_clr = 1; cyc(); wr_en = 0; ovf_clr = 0;
    check("R4 set beats clear", 32'(ovf_event), 32'd1);

    // R9 hold between strobes while fill drains to 27
    do_reads(100);
    check("R9 code held", 32'(just_code), 32'd2);
    strobe();
    hi_thr = 7'd127; lo_thr = 7'd27;
    check("R9 after strobe fill 27 between", 32'(just_code), 32'd0);
    strobe();
    check("R7 fill 27 = low", 32'(just_code), 32'd1);

    // R1 asynchronous reset mid-run
    #2 rst_n = 0; #1;
    check("R1 async reset code", 32'(just_code), 32'd0);
    check("R1 async reset event", 32'(ovf_event), 32'd0);
    cyc(); rst_n = 1; cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule